// File: doc/BRIEF.md
# Add, Reverse-Subtract and Compare Unit

This unit is the integer add/subtract slice of a 32-bit RISC datapath whose instruction bits are numbered from the most significant end (bit 0 is the MSB). Each cycle it receives the 6-bit major opcode and the 11-bit function field of an instruction, the two source register values, the 16-bit immediate of the immediate-form encoding, and the current carry flag. From these it computes a result word, a carry-out, and a strobe that says whether the carry flag should be updated. When it does not recognise the instruction it raises an illegal-instruction flag.

Subtraction in this architecture is reversed. The second source minus the first is formed as `rb + ~ra + 1`. In the carry-chaining forms the `+1` is replaced by the incoming carry flag. The two compare instructions produce that same difference, then overwrite its most significant bit with the outcome of a signed or unsigned "second source below first source" test. Each opcode carries its own fields: one bit picks reverse subtraction, one takes the carry flag as carry-in, one keeps the carry flag unchanged, and one replaces the second source with the sign-extended immediate.

All outputs are registered. A synchronous active-high reset clears them. Results appear one clock after the inputs are sampled.

Top module: `arc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become 0 after that edge (`result_o`, `carry_o`, `carry_we_o`, `illegal_o`).
- R2: Opcode `000000` with function 0 (add) gives `result_o = ra_i + rb_i`, `carry_o` = carry out of bit 31, and `carry_we_o = 1`.
- R3: Opcode `000001` with function 0 (reverse subtract) gives `result_o = rb_i + ~ra_i + 1`, `carry_o` = carry out of that sum (1 when `rb_i >= ra_i` unsigned), and `carry_we_o = 1`.
- R4: Opcode value 2 in the low three bits (opcode LSB-numbered bit 1 set) uses `carry_i` as carry-in. This replaces 0 for add and replaces the constant 1 for reverse subtract. Opcodes `000010`/`000011` are affected, and so are their keep and immediate forms.
- R5: Opcode LSB-numbered bit 2 set (keep forms, e.g. `000100`..`000111`) gives the same result and carry-out as the non-keep form, but `carry_we_o = 0`.
- R6: Opcodes `001000`..`001111` use `{{16{imm_i[15]}}, imm_i}` in place of `rb_i` with the same bit meanings as R2–R5, and ignore `func_i` entirely.
- R7: Opcode `000101` with function `00000000001` (signed compare) gives bits 30:0 of `rb_i - ra_i` and bit 31 = 1 if `$signed(rb_i) < $signed(ra_i)`, else 0. `carry_we_o` is 0.
- R8: Opcode `000101` with function `00000000011` (unsigned compare) is as R7, but bit 31 = 1 iff `rb_i < ra_i` unsigned.
- R9: Any opcode with either of its two MSBs set, and any register-form opcode (`000000`..`000111`) whose function is neither 0 nor a compare code from R7/R8 on opcode `000101`, gives `illegal_o = 1` with `result_o = 0`, `carry_o = 0` and `carry_we_o = 0`.
- R10: Inputs applied before a rising edge appear on the outputs only after that edge; outputs hold between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opc_i | input | 6 | Major opcode (instruction bits 0-5) |
| func_i | input | 11 | Function field (instruction bits 21-31), register forms |
| ra_i | input | 32 | First source register value |
| rb_i | input | 32 | Second source register value |
| imm_i | input | 16 | Immediate field (instruction bits 16-31), immediate forms |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered result word |
| carry_o | output | 1 | Registered carry-out |
| carry_we_o | output | 1 | Registered carry-flag write enable |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 16-bit immediate and 8-bit adder slices. The 8-bit slices let operands such as `0x000000FF + 1` and `0xFFFFFFFF + 1` drive a carry through one or all slice boundaries. Immediates with bit 15 set check that the sign fills the upper half-word. Compare operands straddle the sign boundary, where the signed and unsigned outcomes disagree.

// File: rtl/arc_pkg.sv
package arc_pkg;
  localparam int OPC_W  = 6;
  localparam int FUNC_W = 11;

  typedef struct packed {
    logic legal;
    logic use_imm;
    logic reverse;
    logic use_carry;
    logic keep;
    logic is_cmp;
    logic cmp_unsigned;
  } arc_ctrl_t;
endpackage

// File: rtl/arc_decode.sv
module arc_decode
  import arc_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FUNC_W-1:0] func_i,
  output arc_ctrl_t         ctrl_o
);
  localparam logic [FUNC_W-1:0] FN_CMP_S = FUNC_W'(1);
  localparam logic [FUNC_W-1:0] FN_CMP_U = FUNC_W'(3);

  always_comb begin
    ctrl_o = '0;
    if (opc_i[5:4] == 2'b00) begin
      if (opc_i[3]) begin
        ctrl_o.legal = 1'b1;
      end else if (func_i == '0) begin
        ctrl_o.legal = 1'b1;
      end else if (opc_i[2:0] == 3'b101 && (func_i == FN_CMP_S || func_i == FN_CMP_U)) begin
        ctrl_o.legal        = 1'b1;
        ctrl_o.is_cmp       = 1'b1;
        ctrl_o.cmp_unsigned = func_i[1];
      end
      if (ctrl_o.legal) begin
        ctrl_o.use_imm   = opc_i[3];
        ctrl_o.keep      = opc_i[2];
        ctrl_o.use_carry = opc_i[1];
        ctrl_o.reverse   = opc_i[0];
      end
    end
  end
endmodule

// File: rtl/arc_operand.sv
module arc_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm_i,
  input  logic              reverse_i,
  input  logic              use_carry_i,
  input  logic [DATA_W-1:0] ra_i,
  input  logic [DATA_W-1:0] rb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic              cin_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    op_a_o = reverse_i ? ~ra_i : ra_i;
    op_b_o = use_imm_i ? imm_ext : rb_i;
    cin_o  = use_carry_i ? carry_i : reverse_i;
  end
endmodule

// File: rtl/arc_adder.sv
module arc_adder #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int N_SLICE = DATA_W / SLICE_W;
  localparam int MSB     = DATA_W - 1;

  logic [N_SLICE:0] chain;

  assign chain[0] = cin_i;

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    logic [SLICE_W:0] part;
    assign part = {1'b0, a_i[s*SLICE_W +: SLICE_W]}
                + {1'b0, b_i[s*SLICE_W +: SLICE_W]}
                + {{SLICE_W{1'b0}}, chain[s]};
    assign sum_o[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
    assign chain[s+1] = part[SLICE_W];
  end

  assign cout_o = chain[N_SLICE];
  assign ovf_o  = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/arc_cmp_fix.sv
module arc_cmp_fix #(
  parameter int DATA_W = 32
) (
  input  logic              is_cmp_i,
  input  logic              cmp_unsigned_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int MSB = DATA_W - 1;

  logic below_s;
  logic below_u;

  assign below_s = sum_i[MSB] ^ ovf_i;
  assign below_u = ~cout_i;

  always_comb begin
    res_o = sum_i;
    if (is_cmp_i) res_o[MSB] = cmp_unsigned_i ? below_u : below_s;
  end
endmodule

// File: rtl/arc_unit.sv
module arc_unit
  import arc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        opc_i,
  input  logic [10:0]       func_i,
  input  logic [DATA_W-1:0] ra_i,
  input  logic [DATA_W-1:0] rb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o,
  output logic              illegal_o
);
  localparam int MSB = DATA_W - 1;

  arc_ctrl_t         ctrl;
  logic [DATA_W-1:0] op_a, op_b, sum, fixed;
  logic              cin, cout, ovf;

  arc_decode u_dec (.opc_i(opc_i), .func_i(func_i), .ctrl_o(ctrl));

  arc_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .use_imm_i(ctrl.use_imm), .reverse_i(ctrl.reverse), .use_carry_i(ctrl.use_carry),
    .ra_i(ra_i), .rb_i(rb_i), .imm_i(imm_i), .carry_i(carry_i),
    .op_a_o(op_a), .op_b_o(op_b), .cin_o(cin)
  );

  arc_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_add (
    .a_i(op_a), .b_i(op_b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  arc_cmp_fix #(.DATA_W(DATA_W)) u_cmp (
    .is_cmp_i(ctrl.is_cmp), .cmp_unsigned_i(ctrl.cmp_unsigned),
    .sum_i(sum), .cout_i(cout), .ovf_i(ovf), .res_o(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      carry_o    <= 1'b0;
      carry_we_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      result_o   <= ctrl.legal ? fixed : '0;
      carry_o    <= ctrl.legal & cout;
      carry_we_o <= ctrl.legal & ~ctrl.keep & ~ctrl.is_cmp;
      illegal_o  <= ~ctrl.legal;
    end
  end

  // R2: plain register add
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 6'b000000 && func_i == 11'd0)
      |=> (result_o == DATA_W'($past(ra_i) + $past(rb_i)) && carry_we_o));

  // R5: keep forms never request a carry write
  p_keep_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (opc_i[5:4] == 2'b00 && opc_i[2]) |=> !carry_we_o);

  // R7: signed compare MSB
  p_cmp_signed_r7: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 6'b000101 && func_i == 11'd1)
      |=> (result_o[MSB] == ($signed($past(rb_i)) < $signed($past(ra_i)))));

  // R8: unsigned compare MSB
  p_cmp_unsigned_r8: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 6'b000101 && func_i == 11'd3)
      |=> (result_o[MSB] == ($past(rb_i) < $past(ra_i))));

  // R9: upper opcode bits set is always illegal and quiet
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (opc_i[5:4] != 2'b00) |=> (illegal_o && !carry_we_o && result_o == '0));
endmodule

// File: tb/arc_unit_test.sv
`timescale 1ns/1ps
module arc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opc = '0;
  logic [10:0] func = '0;
  logic [31:0] ra = '0, rb = '0;
  logic [15:0] imm = '0;
  logic        cf = 1'b0;
  logic [31:0] result;
  logic        carry, carry_we, illegal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  arc_unit uut (
    .clk(clk), .rst(rst), .opc_i(opc), .func_i(func), .ra_i(ra), .rb_i(rb),
    .imm_i(imm), .carry_i(cf), .result_o(result), .carry_o(carry),
    .carry_we_o(carry_we), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [10:0] f, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i, input logic c);
    opc = o; func = f; ra = a; rb = b; imm = i; cf = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [31:0] r, input logic co,
                            input logic we, input logic ill);
    chk({req, " result"}, result, r);
    chk({req, " carry"}, {31'd0, carry}, {31'd0, co});
    chk({req, " carry_we"}, {31'd0, carry_we}, {31'd0, we});
    chk({req, " illegal"}, {31'd0, illegal}, {31'd0, ill});
  endtask

  task automatic t_reset_r1();
    chk("R1 reset result", result, 32'd0);
    apply(6'b000000, 11'd0, 32'hFFFF_FFFF, 32'd1, 16'd0, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out("R1", 32'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_add_r2();
    apply(6'b000000, 11'd0, 32'h0000_00FF, 32'h0000_0001, 16'd0, 1'b1);
    expect_out("R2 slice carry", 32'h0000_0100, 1'b0, 1'b1, 1'b0);
    apply(6'b000000, 11'd0, 32'hFFFF_FFFF, 32'h0000_0001, 16'd0, 1'b0);
    expect_out("R2 wrap", 32'h0000_0000, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_rsub_r3();
    apply(6'b000001, 11'd0, 32'd3, 32'd5, 16'd0, 1'b0);
    expect_out("R3 no borrow", 32'd2, 1'b1, 1'b1, 1'b0);
    apply(6'b000001, 11'd0, 32'd5, 32'd3, 16'd0, 1'b1);
    expect_out("R3 borrow", 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0);
    apply(6'b000001, 11'd0, 32'd7, 32'd7, 16'd0, 1'b0);
    expect_out("R3 equal", 32'd0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_carry_r4();
    apply(6'b000010, 11'd0, 32'd10, 32'd20, 16'd0, 1'b1);
    expect_out("R4 add c=1", 32'd31, 1'b0, 1'b1, 1'b0);
    apply(6'b000010, 11'd0, 32'd10, 32'd20, 16'd0, 1'b0);
    expect_out("R4 add c=0", 32'd30, 1'b0, 1'b1, 1'b0);
    apply(6'b000011, 11'd0, 32'd3, 32'd5, 16'd0, 1'b0);
    expect_out("R4 rsub c=0", 32'd1, 1'b1, 1'b1, 1'b0);
    apply(6'b000011, 11'd0, 32'd3, 32'd5, 16'd0, 1'b1);
    expect_out("R4 rsub c=1", 32'd2, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_keep_r5();
    apply(6'b000100, 11'd0, 32'hFFFF_FFFF, 32'd2, 16'd0, 1'b0);
    expect_out("R5 addk", 32'd1, 1'b1, 1'b0, 1'b0);
    apply(6'b000111, 11'd0, 32'd3, 32'd5, 16'd0, 1'b1);
    expect_out("R5 rsubkc", 32'd2, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_imm_r6();
    apply(6'b001000, 11'h7FF, 32'd100, 32'hDEAD_BEEF, 16'hFFFF, 1'b0);
    expect_out("R6 addi neg", 32'd99, 1'b1, 1'b1, 1'b0);
    apply(6'b001001, 11'd0, 32'd1, 32'd0, 16'h8000, 1'b0);
    expect_out("R6 rsubi", 32'hFFFF_7FFF, 1'b1, 1'b1, 1'b0);
    apply(6'b001110, 11'd5, 32'd1, 32'd0, 16'h7FFF, 1'b1);
    expect_out("R6 addikc", 32'h0000_8001, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_signed_r7();
    apply(6'b000101, 11'd1, 32'd1, 32'hFFFF_FFFF, 16'd0, 1'b0);
    expect_out("R7 -1 vs 1", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
    apply(6'b000101, 11'd1, 32'hFFFF_FFFF, 32'd1, 16'd0, 1'b0);
    expect_out("R7 1 vs -1", 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    apply(6'b000101, 11'd1, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0, 1'b0);
    expect_out("R7 overflow", 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cmp_unsigned_r8();
    apply(6'b000101, 11'd3, 32'd1, 32'hFFFF_FFFF, 16'd0, 1'b0);
    expect_out("R8 big vs 1", 32'h7FFF_FFFE, 1'b1, 1'b0, 1'b0);
    apply(6'b000101, 11'd3, 32'hFFFF_FFFF, 32'd1, 16'd0, 1'b0);
    expect_out("R8 1 vs big", 32'h8000_0002, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_illegal_r9();
    apply(6'b010000, 11'd0, 32'd1, 32'd2, 16'd3, 1'b1);
    expect_out("R9 high opcode", 32'd0, 1'b0, 1'b0, 1'b1);
    apply(6'b000000, 11'd2, 32'd1, 32'd2, 16'd0, 1'b0);
    expect_out("R9 bad func", 32'd0, 1'b0, 1'b0, 1'b1);
    apply(6'b000101, 11'd2, 32'd1, 32'd2, 16'd0, 1'b0);
    expect_out("R9 cmp bad func", 32'd0, 1'b0, 1'b0, 1'b1);
    apply(6'b000001, 11'd1, 32'd1, 32'd2, 16'd0, 1'b0);
    expect_out("R9 cmp func other opc", 32'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_latency_r10();
    apply(6'b000000, 11'd0, 32'd4, 32'd5, 16'd0, 1'b0);
    opc = 6'b000000; ra = 32'd40; rb = 32'd50;
    #1;
    chk("R10 hold before edge", result, 32'd9);
    @(posedge clk); @(negedge clk);
    chk("R10 update after edge", result, 32'd90);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_add_r2();
    t_rsub_r3();
    t_carry_r4();
    t_keep_r5();
    t_imm_r6();
    t_cmp_signed_r7();
    t_cmp_unsigned_r8();
    t_illegal_r9();
    t_latency_r10();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule